// File: doc/BRIEF.md
# Memory Race Arc Recorder

This block sits beside one processor of a sequentially consistent shared-memory multiprocessor and writes down the cross-processor ordering arcs that a replayer later needs to run the same interleaving again. It counts committed instructions. For each cached block it keeps a stamp: the count of the last load or store to that block. It also keeps, for every other processor, the newest remote stamp it has already logged.

When another processor asks this one for a block, the block supplies a timestamp to carry on the coherence reply. The coherence layer attaches it to the data response for read-after-write and write-after-write conflicts, and to the invalidate acknowledgement for write-after-read conflicts.

When a reply arrives carrying a remote processor id and timestamp, the arc ends at the local instruction after the current count. The block logs that arc only if the remote stamp is newer than anything already logged from that processor. Arcs that are implied transitively are therefore dropped. Log records leave on a valid/ready port.

Top module: `race_arc_recorder`

## Requirements
- R1: After reset the instruction count is 0, every block stamp is 0, every per-source stamp is 0, log_valid is 0 and rcv_ready is 1.
- R2: inst_count (32 bits) rises by exactly one in the cycle after each cycle with cmt_valid high, and otherwise holds.
- R3: cmt_kind encodes 0 = non-memory, 1 = load, 2 = store, 3 = non-memory. A committed load or store to block cmt_idx sets that block's stamp to the incremented count. A non-memory commit leaves every stamp unchanged.
- R4: A request with req_present high returns req_ts equal to the stamp of block req_idx, and rsp_pid equal to the block's own processor id, in the same cycle.
- R5: A request with req_present low returns req_ts equal to the current instruction count.
- R6: An accepted reply whose rcv_ts is greater than the stored stamp for rcv_src presents, in the next cycle, a record with log_src = rcv_src, log_src_ts = rcv_ts and log_dst_ts = instruction count + 1. The stored stamp for that source then becomes rcv_ts.
- R7: An accepted reply whose rcv_ts is less than or equal to the stored stamp for rcv_src produces no record and leaves that stamp unchanged.
- R8: A reply that names the block's own processor id produces no record.
- R9: When a commit and a reply are presented in the same cycle, log_dst_ts is the count before that commit plus one.
- R10: While log_valid is high and log_ready is low, the record holds stable, rcv_ready is low, and replies presented then are not taken.
- R11: Each source processor has its own stored stamp. A logged arc from one source does not filter replies from another source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmt_valid | input | 1 | One instruction commits this cycle |
| cmt_kind | input | 2 | Access kind of the committing instruction |
| cmt_idx | input | 6 | Block index touched by the commit |
| req_valid | input | 1 | Remote coherence request is being answered |
| req_present | input | 1 | Requested block still holds a valid stamp |
| req_idx | input | 6 | Block index of the request |
| req_ts | output | 32 | Timestamp to carry on the reply |
| rsp_pid | output | 2 | Own processor id to carry on the reply |
| rcv_valid | input | 1 | Coherence reply received |
| rcv_ready | output | 1 | Reply can be taken this cycle |
| rcv_src | input | 2 | Processor id that sent the reply |
| rcv_ts | input | 32 | Timestamp carried by the reply |
| log_valid | output | 1 | Log record is presented |
| log_ready | input | 1 | Log consumer takes the record |
| log_src | output | 2 | Source processor of the arc |
| log_src_ts | output | 32 | Source instruction count of the arc |
| log_dst_ts | output | 32 | Local instruction count ending the arc |
| inst_count | output | 32 | Committed instruction count |

## Verification
The hardest case to reach from the ports is a reply that arrives while a record is stalled: it must be refused without touching the per-source stamp. The bench holds log_ready low, offers a second reply, and then releases the consumer with the reply withdrawn. It then replays the same source with a stamp that would only log if the refused reply left no trace. The same-cycle commit-and-reply case is driven directly with both valids raised on one edge, and the arc end is compared against the count from before the commit.

// File: rtl/arc_rec_pkg.sv
package arc_rec_pkg;
    localparam int CNT_W = 32;
    localparam int NPROC = 4;
    localparam int PID_W = $clog2(NPROC);

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [PID_W-1:0] src;
        logic [CNT_W-1:0] src_ts;
        logic [CNT_W-1:0] dst_ts;
    } arc_rec_t;

    function automatic logic touches_memory(acc_kind_e k);
        return (k == ACC_LOAD) || (k == ACC_STORE);
    endfunction
endpackage

// File: rtl/arc_icount.sv
module arc_icount
    import arc_rec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_inc
);
    logic [CNT_W-1:0] cnt_q;

    assign count_inc = cnt_q + CNT_W'(1);
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (step) cnt_q <= count_inc;
    end
endmodule

// File: rtl/arc_stamp_table.sv
module arc_stamp_table
    import arc_rec_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_val
);
    localparam int DEPTH = 1 << IDX_W;

    logic [CNT_W-1:0] stamp_q [DEPTH];

    assign rd_val = stamp_q[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stamp_q[i] <= '0;
        end else if (wr_en) begin
            stamp_q[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/arc_source_filter.sv
module arc_source_filter
    import arc_rec_pkg::*;
#(
    parameter int SELF_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             probe,
    input  logic [PID_W-1:0] probe_src,
    input  logic [CNT_W-1:0] probe_ts,
    output logic             newer
);
    logic [CNT_W-1:0] seen [NPROC];
    logic             hit_self;
    logic             do_upd;

    assign hit_self = (probe_src == PID_W'(SELF_ID));
    assign newer    = probe && !hit_self && (probe_ts > seen[probe_src]);
    assign do_upd   = newer;

    for (genvar p = 0; p < NPROC; p++) begin : g_src
        if (p == SELF_ID) begin : g_self
            assign seen[p] = '0;
        end else begin : g_remote
            logic [CNT_W-1:0] seen_q;
            always_ff @(posedge clk) begin
                if (rst)
                    seen_q <= '0;
                else if (do_upd && probe_src == PID_W'(p))
                    seen_q <= probe_ts;
            end
            assign seen[p] = seen_q;
        end
    end
endmodule

// File: rtl/race_arc_recorder.sv
module race_arc_recorder
    import arc_rec_pkg::*;
#(
    parameter int SELF_ID = 0,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmt_valid,
    input  logic [1:0]       cmt_kind,
    input  logic [IDX_W-1:0] cmt_idx,
    input  logic             req_valid,
    input  logic             req_present,
    input  logic [IDX_W-1:0] req_idx,
    output logic [CNT_W-1:0] req_ts,
    output logic [PID_W-1:0] rsp_pid,
    input  logic             rcv_valid,
    output logic             rcv_ready,
    input  logic [PID_W-1:0] rcv_src,
    input  logic [CNT_W-1:0] rcv_ts,
    output logic             log_valid,
    input  logic             log_ready,
    output logic [PID_W-1:0] log_src,
    output logic [CNT_W-1:0] log_src_ts,
    output logic [CNT_W-1:0] log_dst_ts,
    output logic [CNT_W-1:0] inst_count
);
    logic [CNT_W-1:0] cnt_now;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] stamp_rd;
    logic             stamp_wr;
    logic             take;
    logic             keep;
    logic             pend_q;
    arc_rec_t         rec_q;
    acc_kind_e        kind;

    assign kind     = acc_kind_e'(cmt_kind);
    assign stamp_wr = cmt_valid && touches_memory(kind);

    arc_icount u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step      (cmt_valid),
        .count     (cnt_now),
        .count_inc (cnt_inc)
    );

    arc_stamp_table #(.IDX_W(IDX_W)) u_tab (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (stamp_wr),
        .wr_idx (cmt_idx),
        .wr_val (cnt_inc),
        .rd_idx (req_idx),
        .rd_val (stamp_rd)
    );

    assign req_ts  = (req_valid && req_present) ? stamp_rd : cnt_now;
    assign rsp_pid = PID_W'(SELF_ID);

    assign rcv_ready = !pend_q || log_ready;
    assign take      = rcv_valid && rcv_ready;

    arc_source_filter #(.SELF_ID(SELF_ID)) u_flt (
        .clk       (clk),
        .rst       (rst),
        .probe     (take),
        .probe_src (rcv_src),
        .probe_ts  (rcv_ts),
        .newer     (keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            rec_q  <= '0;
        end else if (keep) begin
            pend_q       <= 1'b1;
            rec_q.src    <= rcv_src;
            rec_q.src_ts <= rcv_ts;
            rec_q.dst_ts <= cnt_inc;
        end else if (log_ready) begin
            pend_q <= 1'b0;
        end
    end

    assign log_valid  = pend_q;
    assign log_src    = rec_q.src;
    assign log_src_ts = rec_q.src_ts;
    assign log_dst_ts = rec_q.dst_ts;
    assign inst_count = cnt_now;
endmodule

// File: rtl/race_arc_recorder_chk.sv
module race_arc_recorder_chk
    import arc_rec_pkg::*;
#(
    parameter int SELF_ID = 0,
    parameter int IDX_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cmt_valid,
    input logic             req_valid,
    input logic [CNT_W-1:0] req_ts,
    input logic             rcv_valid,
    input logic             rcv_ready,
    input logic             log_valid,
    input logic             log_ready,
    input logic [PID_W-1:0] log_src,
    input logic [CNT_W-1:0] log_src_ts,
    input logic [CNT_W-1:0] log_dst_ts,
    input logic [CNT_W-1:0] inst_count
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |=> inst_count == $past(inst_count) + CNT_W'(1));

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmt_valid |=> $stable(inst_count));

    // R5
    stamp_bound_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_ts <= inst_count);

    // R10
    stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (log_valid && !log_ready) |-> !rcv_ready);

    // R10
    hold_record_chk: assert property (@(posedge clk) disable iff (rst)
        (log_valid && !log_ready) |=>
            (log_valid && $stable(log_src) && $stable(log_src_ts) && $stable(log_dst_ts)));

    // R6
    record_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(log_valid) |-> $past(rcv_valid && rcv_ready));

    // R8
    not_self_chk: assert property (@(posedge clk) disable iff (rst)
        log_valid |-> log_src != PID_W'(SELF_ID));
endmodule

bind race_arc_recorder race_arc_recorder_chk #(.SELF_ID(SELF_ID), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_race_arc_recorder.sv
module sim_race_arc_recorder;
    localparam int SELF = 0;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmt_valid;
    logic [1:0]  cmt_kind;
    logic [5:0]  cmt_idx;
    logic        req_valid;
    logic        req_present;
    logic [5:0]  req_idx;
    logic [31:0] req_ts;
    logic [1:0]  rsp_pid;
    logic        rcv_valid;
    logic        rcv_ready;
    logic [1:0]  rcv_src;
    logic [31:0] rcv_ts;
    logic        log_valid;
    logic        log_ready;
    logic [1:0]  log_src;
    logic [31:0] log_src_ts;
    logic [31:0] log_dst_ts;
    logic [31:0] inst_count;

    int checks = 0;
    int errors = 0;
    int exp_cnt = 0;

    always #10 clk = ~clk;

    race_arc_recorder #(.SELF_ID(SELF), .IDX_W(6)) u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmt_valid = 0; cmt_kind = 0; cmt_idx = 0;
        req_valid = 0; req_present = 0; req_idx = 0;
        rcv_valid = 0; rcv_src = 0; rcv_ts = 0;
    endtask

    task automatic commit(logic [1:0] k, logic [5:0] idx);
        cmt_valid = 1; cmt_kind = k; cmt_idx = idx;
        @(negedge clk);
        cmt_valid = 0;
        exp_cnt++;
    endtask

    task automatic query(logic pres, logic [5:0] idx, output logic [31:0] ts);
        req_valid = 1; req_present = pres; req_idx = idx;
        #1 ts = req_ts;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic reply(logic [1:0] src, logic [31:0] ts);
        rcv_valid = 1; rcv_src = src; rcv_ts = ts;
        @(negedge clk);
        rcv_valid = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 count", inst_count, 0);
        check("R1 log_valid", 32'(log_valid), 0);
        check("R1 rcv_ready", 32'(rcv_ready), 1);
        query(1, 6'd5, v);
        check("R1 stamp", v, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) commit(2'd0, 6'd7);
        check("R2 count", inst_count, 32'(exp_cnt));
        commit(2'd3, 6'd7);
        query(1, 6'd7, v);
        check("R3 non-memory keeps stamp", v, 0);
    endtask

    task automatic t_stamp();
        logic [31:0] v;
        commit(2'd1, 6'd7);
        commit(2'd2, 6'd9);
        commit(2'd0, 6'd0);
        commit(2'd0, 6'd0);
        check("R2 count", inst_count, 32'(exp_cnt));
        query(1, 6'd7, v);
        check("R3 load stamp", v, 5);
        check("R4 pid", 32'(rsp_pid), SELF);
        query(1, 6'd9, v);
        check("R4 store stamp", v, 6);
        query(0, 6'd9, v);
        check("R5 absent uses count", v, 32'(exp_cnt));
    endtask

    task automatic t_log();
        log_ready = 1;
        reply(2'd1, 32'd10);
        check("R6 valid", 32'(log_valid), 1);
        check("R6 src", 32'(log_src), 1);
        check("R6 src_ts", log_src_ts, 10);
        check("R6 dst_ts", log_dst_ts, 32'(exp_cnt + 1));
        @(negedge clk);
        check("R6 drained", 32'(log_valid), 0);
    endtask

    task automatic t_filter();
        reply(2'd1, 32'd10);
        check("R7 equal ts dropped", 32'(log_valid), 0);
        reply(2'd1, 32'd9);
        check("R7 older ts dropped", 32'(log_valid), 0);
        reply(2'd2, 32'd3);
        check("R11 other source logs", 32'(log_valid), 1);
        check("R11 src", 32'(log_src), 2);
        reply(2'd1, 32'd11);
        check("R7 stamp updated to 10, 11 logs", 32'(log_valid), 1);
        @(negedge clk);
    endtask

    task automatic t_self();
        reply(2'(SELF), 32'd100);
        check("R8 own id ignored", 32'(log_valid), 0);
    endtask

    task automatic t_same();
        int pre;
        pre = exp_cnt;
        rcv_valid = 1; rcv_src = 2'd3; rcv_ts = 32'd50;
        commit(2'd1, 6'd1);
        rcv_valid = 0;
        check("R9 valid", 32'(log_valid), 1);
        check("R9 dst uses pre-commit count", log_dst_ts, 32'(pre + 1));
        check("R9 count", inst_count, 32'(exp_cnt));
        @(negedge clk);
    endtask

    task automatic t_stall();
        log_ready = 0;
        reply(2'd1, 32'd20);
        check("R10 valid", 32'(log_valid), 1);
        check("R10 ready low", 32'(rcv_ready), 0);
        reply(2'd2, 32'd40);
        check("R10 still valid", 32'(log_valid), 1);
        check("R10 src stable", 32'(log_src), 1);
        check("R10 ts stable", log_src_ts, 20);
        log_ready = 1;
        @(negedge clk);
        check("R10 released", 32'(log_valid), 0);
        reply(2'd2, 32'd4);
        check("R10 refused reply left stamp", 32'(log_valid), 1);
        check("R10 src_ts", log_src_ts, 4);
        @(negedge clk);
    endtask

    initial begin
        idle_inputs();
        log_ready = 1;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_count();
        t_stamp();
        t_log();
        t_filter();
        t_self();
        t_same();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule